// File: doc/BRIEF.md
# Sensor Serial Command Decoder

This block sits between a host controller and the timing and exposure logic of an area image sensor. The host writes 16-bit command words over a three-wire serial port made of an enable line, a serial clock and a data line. The serial clock runs at no more than a quarter of the master clock. All three wires are brought into the master clock domain through synchronizers, and the block detects the serial clock edges there.

Each complete word carries a 4-bit selector and a payload. The selector picks which control setting the word writes: the 10-bit amplifier gain code, the exposure setting, or the two single-bit mode flags (frame rate and clamp behaviour). The exposure payload has two meanings. It can give an exposure length in lines, or it can use a reserved bit pattern to ask for a storage time that spans several frames.

The decoded settings are held in registers and driven as parallel outputs. A word whose transfer is cut short has no effect.

Top module: `sensor_cmd_decoder`

## Requirements
- R1: While `rst` is high, and after it falls, the outputs hold their defaults until a word is committed: `gainCode` = 10'h3FF, `exposureLines` = 525, `longStorage` = 0, `storageFrames` = 1, `monitorFast` = 0, `clampManual` = 0.
- R2: Bits are taken on rising `serClk` edges while `serEn` is high, D0 first. When `serEn` falls after at least 16 bits, the word made of the last 16 bits received (D15 last) is committed. Earlier surplus bits are dropped.
- R3: If `serEn` falls after fewer than 16 bits, nothing is committed and every output keeps its value.
- R4: Selector D15..D12 = 4'b0000 loads `gainCode` with D11..D2, with D11 as the MSB.
- R5: Selector 4'b1010 with payload D11..D2 = 0 turns the shutter off: `exposureLines` = 525 and `longStorage` = 0.
- R6: Selector 4'b1010 with payload N from 1 to 523 gives `exposureLines` = N+1. Any payload from 524 upward that does not match the R7 pattern saturates to 524.
- R7: Selector 4'b1010 with D11:D10 = 2'b11 and D9..D6 = 4'b0000 sets `longStorage` = 1, `storageFrames` = D5..D2 + 1 and `exposureLines` = 525. In every other exposure setting `storageFrames` = 1.
- R8: Selector 4'b1111 loads `monitorFast` from D1 (1 = 60 fps, 0 = 30 fps) and `clampManual` from D0 (1 = manual/off, 0 = automatic).
- R9: A word with any other selector value is ignored and no output changes.
- R10: A committed word changes only the setting its selector names. All other outputs hold.
- R11: `serClk` edges while `serEn` is low shift nothing and commit nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| serEn | input | 1 | Serial word enable, high during a transfer |
| serClk | input | 1 | Serial bit clock, at most clk/4 |
| serData | input | 1 | Serial data, D0 first |
| gainCode | output | 10 | Amplifier gain code |
| exposureLines | output | 10 | Exposure length in lines (2 to 525) |
| longStorage | output | 1 | Multi-frame storage selected |
| storageFrames | output | 5 | Storage time in frames (1 to 16) |
| monitorFast | output | 1 | 1 = 60 fps monitoring rate |
| clampManual | output | 1 | 1 = clamp manual/off |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 10-bit payload, a 4-bit frame field, two synchronizer stages and a 525-line frame. With these values the real boundaries can be reached in a short run: the exposure step from 523 to 524 lines, saturation above that, and both ends of the 2- to 16-frame storage range. A serial bit period of eight master cycles puts each edge through the full synchronizer and edge-detect path. It also covers words with too few bits, too many bits, and clock edges with the enable low.

// File: rtl/sens_cmd_pkg.sv
package sens_cmd_pkg;

  // Selector codes carried in the top four bits of a command word
  localparam logic [3:0] SEL_GAIN    = 4'b0000;
  localparam logic [3:0] SEL_SHUTTER = 4'b1010;
  localparam logic [3:0] SEL_MODE    = 4'b1111;

  // Strobes passed from the serial control to the datapath
  typedef struct packed {
    logic shiftBit;  // take bitVal into the shift register this cycle
    logic bitVal;    // synchronized serial data
    logic commit;    // a full word is present, decode and write it
  } cmdStrobe_t;

endpackage

// File: rtl/sens_cmd_ctrl.sv
module sens_cmd_ctrl
  import sens_cmd_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       serEn,
  input  logic       serClk,
  input  logic       serData,
  output cmdStrobe_t stb
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  // Synchronizer chain: bit 2 = enable, bit 1 = clock, bit 0 = data
  logic [2:0] syncPipe [SYNC_STAGES];

  genvar gs;
  generate
    for (gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
      if (gs == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncPipe[gs] <= '0;
          else     syncPipe[gs] <= {serEn, serClk, serData};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncPipe[gs] <= '0;
          else     syncPipe[gs] <= syncPipe[gs-1];
        end
      end
    end
  endgenerate

  logic enS, clkS, dataS;
  assign enS   = syncPipe[SYNC_STAGES-1][2];
  assign clkS  = syncPipe[SYNC_STAGES-1][1];
  assign dataS = syncPipe[SYNC_STAGES-1][0];

  logic enPrev, clkPrev;
  always_ff @(posedge clk) begin
    if (rst) begin
      enPrev  <= 1'b0;
      clkPrev <= 1'b0;
    end else begin
      enPrev  <= enS;
      clkPrev <= clkS;
    end
  end

  logic sclkRise, enFall;
  assign sclkRise = clkS & ~clkPrev;
  assign enFall   = enPrev & ~enS;

  // Bit counter, saturating at one full word
  logic [CNT_W-1:0] bitCnt;
  always_ff @(posedge clk) begin
    if (rst || !enS) begin
      bitCnt <= '0;
    end else if (sclkRise && bitCnt != FULL_CNT) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign stb.shiftBit = sclkRise & enS;
  assign stb.bitVal   = dataS;
  assign stb.commit   = enFall & (bitCnt == FULL_CNT);

endmodule

// File: rtl/sens_cmd_dpath.sv
module sens_cmd_dpath
  import sens_cmd_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int SEL_W      = 4,
  parameter int PAY_W      = 10,
  parameter int FRAME_W    = 4,
  parameter int FULL_LINES = 525,
  parameter int MAX_LINES  = 524,
  localparam int LINE_W    = $clog2(FULL_LINES + 1),
  localparam int FRM_W     = FRAME_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  cmdStrobe_t        stb,
  output logic [PAY_W-1:0]  gainCode,
  output logic [LINE_W-1:0] exposureLines,
  output logic              longStorage,
  output logic [FRM_W-1:0]  storageFrames,
  output logic              monitorFast,
  output logic              clampManual
);

  localparam int PAY_LO  = WORD_W - SEL_W - PAY_W;   // lowest payload bit
  localparam int MODE_W  = 2;                        // monitor and clamp flags
  localparam int GAP_W   = PAY_W - 2 - FRAME_W;      // must be zero in long mode

  logic [WORD_W-1:0] shiftReg;
  always_ff @(posedge clk) begin
    if (rst)               shiftReg <= '0;
    else if (stb.shiftBit) shiftReg <= {stb.bitVal, shiftReg[WORD_W-1:1]};
  end

  logic [SEL_W-1:0] sel;
  logic [PAY_W-1:0] payload;
  assign sel     = shiftReg[WORD_W-1 -: SEL_W];
  assign payload = shiftReg[PAY_LO +: PAY_W];

  logic [PAY_W-1:0]  gainReg;
  logic [PAY_W-1:0]  shutReg;
  logic [MODE_W-1:0] modeReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      gainReg <= '1;
      shutReg <= '0;
    end else if (stb.commit) begin
      if (sel == SEL_GAIN)    gainReg <= payload;
      if (sel == SEL_SHUTTER) shutReg <= payload;
    end
  end

  genvar gm;
  generate
    for (gm = 0; gm < MODE_W; gm++) begin : g_mode
      always_ff @(posedge clk) begin
        if (rst)                                 modeReg[gm] <= 1'b0;
        else if (stb.commit && sel == SEL_MODE)  modeReg[gm] <= shiftReg[gm];
      end
    end
  endgenerate

  // Exposure decode
  logic isLong;
  assign isLong = (shutReg[PAY_W-1 -: 2] == 2'b11) &&
                  (shutReg[FRAME_W +: GAP_W] == '0);

  always_comb begin
    if (shutReg == '0 || isLong) begin
      exposureLines = LINE_W'(FULL_LINES);
    end else if (shutReg >= PAY_W'(MAX_LINES)) begin
      exposureLines = LINE_W'(MAX_LINES);
    end else begin
      exposureLines = LINE_W'(shutReg) + 1'b1;
    end
  end

  always_comb begin
    if (isLong) storageFrames = {1'b0, shutReg[FRAME_W-1:0]} + 1'b1;
    else        storageFrames = FRM_W'(1);
  end

  assign longStorage = isLong;
  assign gainCode    = gainReg;
  assign monitorFast = modeReg[1];
  assign clampManual = modeReg[0];

endmodule

// File: rtl/sensor_cmd_decoder.sv
module sensor_cmd_decoder
  import sens_cmd_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SEL_W       = 4,
  parameter int PAY_W       = 10,
  parameter int FRAME_W     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FULL_LINES  = 525,
  parameter int MAX_LINES   = 524,
  localparam int LINE_W     = $clog2(FULL_LINES + 1),
  localparam int FRM_W      = FRAME_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serEn,
  input  logic              serClk,
  input  logic              serData,
  output logic [PAY_W-1:0]  gainCode,
  output logic [LINE_W-1:0] exposureLines,
  output logic              longStorage,
  output logic [FRM_W-1:0]  storageFrames,
  output logic              monitorFast,
  output logic              clampManual
);

  cmdStrobe_t ctlStb;
  logic       commitPulse;
  assign commitPulse = ctlStb.commit;

  sens_cmd_ctrl #(
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .serEn   (serEn),
    .serClk  (serClk),
    .serData (serData),
    .stb     (ctlStb)
  );

  sens_cmd_dpath #(
    .WORD_W     (WORD_W),
    .SEL_W      (SEL_W),
    .PAY_W      (PAY_W),
    .FRAME_W    (FRAME_W),
    .FULL_LINES (FULL_LINES),
    .MAX_LINES  (MAX_LINES)
  ) u_dpath (
    .clk           (clk),
    .rst           (rst),
    .stb           (ctlStb),
    .gainCode      (gainCode),
    .exposureLines (exposureLines),
    .longStorage   (longStorage),
    .storageFrames (storageFrames),
    .monitorFast   (monitorFast),
    .clampManual   (clampManual)
  );

endmodule

// File: rtl/sens_cmd_checker.sv
module sens_cmd_checker #(
  parameter int PAY_W      = 10,
  parameter int LINE_W     = 10,
  parameter int FRM_W      = 5,
  parameter int FULL_LINES = 525
) (
  input logic              clk,
  input logic              rst,
  input logic              commitPulse,
  input logic [PAY_W-1:0]  gainCode,
  input logic [LINE_W-1:0] exposureLines,
  input logic              longStorage,
  input logic [FRM_W-1:0]  storageFrames,
  input logic              monitorFast,
  input logic              clampManual
);

  AST_RESET_GAIN: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (gainCode == '1 && !monitorFast && !clampManual && !longStorage)); // R1

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !$past(commitPulse) |-> ($stable(gainCode) && $stable(exposureLines) &&
                             $stable(longStorage) && $stable(monitorFast) &&
                             $stable(clampManual))); // R3

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $past(commitPulse) |-> ($stable(gainCode) ||
                            ($stable(exposureLines) && $stable(longStorage) &&
                             $stable(monitorFast) && $stable(clampManual)))); // R10

  AST_LINES_RANGE: assert property (@(posedge clk) disable iff (rst)
    (exposureLines >= LINE_W'(2)) && (exposureLines <= LINE_W'(FULL_LINES))); // R6

  AST_LONG_FULL_FRAME: assert property (@(posedge clk) disable iff (rst)
    longStorage |-> (exposureLines == LINE_W'(FULL_LINES) && storageFrames != '0)); // R7

  AST_SINGLE_FRAME: assert property (@(posedge clk) disable iff (rst)
    !longStorage |-> (storageFrames == FRM_W'(1))); // R7

endmodule

bind sensor_cmd_decoder sens_cmd_checker #(
  .PAY_W      (PAY_W),
  .LINE_W     (LINE_W),
  .FRM_W      (FRM_W),
  .FULL_LINES (FULL_LINES)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .commitPulse   (commitPulse),
  .gainCode      (gainCode),
  .exposureLines (exposureLines),
  .longStorage   (longStorage),
  .storageFrames (storageFrames),
  .monitorFast   (monitorFast),
  .clampManual   (clampManual)
);

// File: tb/sim_sensor_cmd_decoder.sv
module sim_sensor_cmd_decoder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serEn = 1'b0, serClk = 1'b0, serData = 1'b0;
  logic [9:0] gainCode;
  logic [9:0] exposureLines;
  logic       longStorage;
  logic [4:0] storageFrames;
  logic       monitorFast, clampManual;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  sensor_cmd_decoder u0 (
    .clk(clk), .rst(rst), .serEn(serEn), .serClk(serClk), .serData(serData),
    .gainCode(gainCode), .exposureLines(exposureLines), .longStorage(longStorage),
    .storageFrames(storageFrames), .monitorFast(monitorFast), .clampManual(clampManual)
  );

  // {word, gain, lines, long, frames, monitor, clamp}: state after each word
  localparam int NV = 12;
  localparam logic [43:0] VEC [NV] = '{
    {16'h0800, 10'h200, 10'd525, 1'b0, 5'd1,  1'b0, 1'b0},  // R4
    {16'h0554, 10'h155, 10'd525, 1'b0, 5'd1,  1'b0, 1'b0},  // R4
    {16'hA004, 10'h155, 10'd2,   1'b0, 5'd1,  1'b0, 1'b0},  // R6 N=1
    {16'hA82C, 10'h155, 10'd524, 1'b0, 5'd1,  1'b0, 1'b0},  // R6 N=523
    {16'hA960, 10'h155, 10'd524, 1'b0, 5'd1,  1'b0, 1'b0},  // R6 saturate
    {16'hAC04, 10'h155, 10'd525, 1'b1, 5'd2,  1'b0, 1'b0},  // R7 2 frames
    {16'hAC3C, 10'h155, 10'd525, 1'b1, 5'd16, 1'b0, 1'b0},  // R7 16 frames
    {16'hA000, 10'h155, 10'd525, 1'b0, 5'd1,  1'b0, 1'b0},  // R5 off
    {16'hF002, 10'h155, 10'd525, 1'b0, 5'd1,  1'b1, 1'b0},  // R8
    {16'hF001, 10'h155, 10'd525, 1'b0, 5'd1,  1'b0, 1'b1},  // R8
    {16'h5FFC, 10'h155, 10'd525, 1'b0, 5'd1,  1'b0, 1'b1},  // R9
    {16'hF003, 10'h155, 10'd525, 1'b0, 5'd1,  1'b1, 1'b1}   // R10
  };
  localparam int VREQ [NV] = '{4, 4, 6, 6, 6, 7, 7, 5, 8, 8, 9, 10};

  task automatic checkOne(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkState(input string tag, input int g, input int ln, input int lg,
                            input int fr, input int mo, input int cl);
    checkOne(tag, "gainCode", int'(gainCode), g);
    checkOne(tag, "exposureLines", int'(exposureLines), ln);
    checkOne(tag, "longStorage", int'(longStorage), lg);
    checkOne(tag, "storageFrames", int'(storageFrames), fr);
    checkOne(tag, "monitorFast", int'(monitorFast), mo);
    checkOne(tag, "clampManual", int'(clampManual), cl);
  endtask

  // Send n bits, bits[0] first, with or without the enable raised
  task automatic sendRaw(input logic [31:0] bits, input int n, input bit withEn);
    @(negedge clk);
    serEn = withEn;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      serData = bits[i];
      repeat (4) @(negedge clk);
      serClk = 1'b1;
      repeat (4) @(negedge clk);
      serClk = 1'b0;
    end
    repeat (4) @(negedge clk);
    serEn = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    checkState("R1 in reset", 10'h3FF, 525, 0, 1, 0, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    checkState("R1 after reset", 10'h3FF, 525, 0, 1, 0, 0);

    for (int v = 0; v < NV; v++) begin
      sendRaw({16'h0, VEC[v][43:28]}, 16, 1'b1);
      checkState($sformatf("R%0d vector %0d", VREQ[v], v), int'(VEC[v][27:18]),
                 int'(VEC[v][17:8]), int'(VEC[v][7]), int'(VEC[v][6:2]),
                 int'(VEC[v][1]), int'(VEC[v][0]));
    end

    // R3: ten bits of a gain word then enable drops
    sendRaw(32'h0000_0000, 10, 1'b1);
    checkState("R3 partial word", 10'h155, 525, 0, 1, 1, 1);

    // R11: clock edges while enable is low
    sendRaw(32'h0000_0000, 16, 1'b0);
    checkState("R11 enable low", 10'h155, 525, 0, 1, 1, 1);

    // R2: four surplus leading bits, the last 16 form gain 0x0AA
    sendRaw({12'h0, 16'h02A8, 4'b1011}, 20, 1'b1);
    checkState("R2 surplus bits", 10'h0AA, 525, 0, 1, 1, 1);

    // R1: reset again restores every default
    sendRaw({16'h0, 16'hAC3C}, 16, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    checkState("R1 reapplied", 10'h3FF, 525, 0, 1, 0, 0);

    finishRun();
  end

endmodule